// File: doc/BRIEF.md
# 4-PAM Soft Symbol-to-Bit LLR Mapper

This block sits after the linear filter stage of an iterative receiver. Each cycle it may take one signed fixed-point estimate of a transmitted 4-level amplitude symbol. For each estimate it returns two signed log-likelihood ratios, one for each bit that the symbol carries. Each ratio is the max-log approximation: the smallest squared distance to the symbols whose bit is 0, minus the smallest squared distance to the symbols whose bit is 1. The scale constant is chosen so that the noise variance cancels, and the block therefore has no variance input.

The estimate is first saturated and floored to a 7-bit signed address. The address selects one entry of a 128-entry mapping, and each entry holds both 7-bit results. A parameter chooses how the mapping is built. In one variant it is a constant table filled at elaboration. In the other it is computed directly with arithmetic. Both variants must return bit-identical results. The outputs are registered and carry a valid strobe.

Top module: `pam4_llr_mapper`

## Requirements
- R1: The symbol levels are −3 for bits (0,1), −1 for (0,0), +1 for (1,0) and +3 for (1,1), where the pair is written (first bit, second bit). Let q be the signed address and let one level unit equal 16 address steps. `out_llr0` is the first-bit ratio and `out_llr1` is the second-bit ratio. Each ratio equals (min squared distance in address steps to the bit-0 levels − min squared distance to the bit-1 levels) / 64, before clipping.
- R2: The address is floor(in_est / 16), because in_est has 8 fraction bits and the address has 4. The address is then saturated to −64..+63.
- R3: Each LLR is clipped to −63..+63. The value −64 never appears on an output.
- R4: An estimate of exactly 0 gives `out_llr0` = 0. An estimate of exactly ±2.0 (in_est = ±512) gives `out_llr1` = 0.
- R5: The result for an input accepted with `in_valid` high appears one clock later, with `out_valid` high. `out_valid` is low in every cycle that follows a cycle with `in_valid` low.
- R6: While `in_valid` is low, both LLR outputs keep their values, whatever `in_est` carries.
- R7: After a synchronous active-low reset, `out_valid` is 0 and both LLRs are 0.
- R8: The table variant (USE_TABLE=1) and the arithmetic variant (USE_TABLE=0) give identical outputs for every input.
- R9: `out_llr0` is non-negative for a non-negative estimate and strictly negative for a negative estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Estimate strobe |
| in_est | input | IN_W (12) | Signed estimate, IN_FRAC (8) fraction bits |
| out_valid | output | 1 | LLR strobe, one cycle after in_valid |
| out_llr0 | output | LLR_W (7) | Signed first-bit LLR |
| out_llr1 | output | LLR_W (7) | Signed second-bit LLR |

## Verification
The assertions on sign and on the zero point take `in_est` as a plain two's-complement value. They assume `in_valid` is a clean level that is sampled at the clock edge. They do not assume that the estimate is in range, because saturation is part of the behaviour under test. The stimulus sweeps every 12-bit estimate, including both rails and the ±2.0 and 0 boundaries. It changes inputs only on the falling edge, and it inserts idle cycles with a changing `in_est` so that the hold and strobe behaviour is exercised.

// File: rtl/pam4_llr_pkg.sv
// Package: shared arithmetic for the 4-PAM LLR mapper.
// All functions work on integer address steps; one level unit = u steps.
// Results are in units of 4/u, which keeps every value an exact integer.
package pam4_llr_pkg;

    // First-bit ratio: linear with slope 1 inside |q|<=2u, slope 2 beyond.
    function automatic int bit0_ratio(input int q, input int u);
        if (q > 2 * u)       return 2 * q - 2 * u;
        else if (q < -2 * u) return 2 * q + 2 * u;
        else                 return q;
    endfunction

    // Second-bit ratio: V shape with its zeros at |q| = 2u.
    function automatic int bit1_ratio(input int q, input int u);
        return ((q < 0) ? -q : q) - 2 * u;
    endfunction

    // Symmetric clip to +-m.
    function automatic int clip_sym(input int v, input int m);
        if (v > m)       return m;
        else if (v < -m) return -m;
        else             return v;
    endfunction

endpackage

// File: rtl/pam4_est_quant.sv
// Module: pam4_est_quant
// Floors the signed estimate to the address grid, then saturates it to the
// signed ADDR_W range. Assumes IN_FRAC >= ADDR_FRAC. Purely combinational.
module pam4_est_quant #(
    parameter int IN_W      = 12,
    parameter int IN_FRAC   = 8,
    parameter int ADDR_W    = 7,
    parameter int ADDR_FRAC = 4
) (
    input  logic signed [IN_W-1:0]   est,
    output logic signed [ADDR_W-1:0] addr
);
    localparam int SHIFT = IN_FRAC - ADDR_FRAC;
    localparam int AMAX  = (1 << (ADDR_W - 1)) - 1;
    localparam int AMIN  = -(1 << (ADDR_W - 1));

    logic signed [IN_W-1:0] floored;
    int                     fl_int;

    // Arithmetic shift gives floor division for both signs.
    always_comb begin
        floored = est >>> SHIFT;
        fl_int  = int'(floored);
        if (fl_int > AMAX)      addr = ADDR_W'(AMAX);
        else if (fl_int < AMIN) addr = ADDR_W'(AMIN);
        else                    addr = ADDR_W'(fl_int);
    end
endmodule

// File: rtl/pam4_llr_lookup.sv
// Module: pam4_llr_lookup
// Maps a signed address to the two clipped LLRs. USE_TABLE=1 builds a
// constant table of 2^ADDR_W entries at elaboration; USE_TABLE=0 evaluates
// the same functions directly. Assumes ADDR_FRAC >= 2 so results are exact.
module pam4_llr_lookup
    import pam4_llr_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int ADDR_FRAC = 4,
    parameter int LLR_W     = 7,
    parameter bit USE_TABLE = 1'b1
) (
    input  logic signed [ADDR_W-1:0] addr,
    output logic signed [LLR_W-1:0]  llr0,
    output logic signed [LLR_W-1:0]  llr1
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int UNIT  = 1 << ADDR_FRAC;
    localparam int LMAX  = (1 << (LLR_W - 1)) - 1;

    generate
        if (USE_TABLE) begin : g_table
            logic [2*LLR_W-1:0] tbl [DEPTH];
            // Fill each entry with the pair for its two's-complement address.
            for (genvar a = 0; a < DEPTH; a++) begin : g_entry
                localparam int QA = (a >= DEPTH / 2) ? a - DEPTH : a;
                assign tbl[a] = {LLR_W'(clip_sym(bit0_ratio(QA, UNIT), LMAX)),
                                 LLR_W'(clip_sym(bit1_ratio(QA, UNIT), LMAX))};
            end
            // Read the selected entry.
            assign {llr0, llr1} = tbl[$unsigned(addr)];
        end else begin : g_arith
            int qa;
            // Evaluate both ratios directly from the address.
            always_comb begin
                qa   = int'(addr);
                llr0 = LLR_W'(clip_sym(bit0_ratio(qa, UNIT), LMAX));
                llr1 = LLR_W'(clip_sym(bit1_ratio(qa, UNIT), LMAX));
            end
        end
    endgenerate
endmodule

// File: rtl/pam4_llr_mapper.sv
// Module: pam4_llr_mapper (top)
// Quantizes a 4-PAM estimate, maps it to two per-bit LLRs and registers the
// result with one cycle of latency. Outputs hold while no input is valid.
// Assumes a synchronous active-low reset and a single clock.
module pam4_llr_mapper #(
    parameter int IN_W      = 12,
    parameter int IN_FRAC   = 8,
    parameter int ADDR_W    = 7,
    parameter int ADDR_FRAC = 4,
    parameter int LLR_W     = 7,
    parameter bit USE_TABLE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_est,
    output logic                    out_valid,
    output logic signed [LLR_W-1:0] out_llr0,
    output logic signed [LLR_W-1:0] out_llr1
);
    localparam int TWO_RAW = 2 << IN_FRAC;

    logic signed [ADDR_W-1:0] addr;
    logic signed [LLR_W-1:0]  llr0_c;
    logic signed [LLR_W-1:0]  llr1_c;

    pam4_est_quant #(
        .IN_W(IN_W), .IN_FRAC(IN_FRAC), .ADDR_W(ADDR_W), .ADDR_FRAC(ADDR_FRAC)
    ) u_quant (
        .est(in_est), .addr(addr)
    );

    pam4_llr_lookup #(
        .ADDR_W(ADDR_W), .ADDR_FRAC(ADDR_FRAC), .LLR_W(LLR_W), .USE_TABLE(USE_TABLE)
    ) u_lookup (
        .addr(addr), .llr0(llr0_c), .llr1(llr1_c)
    );

    // Output register: load on a valid input, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_llr0  <= '0;
            out_llr1  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_llr0 <= llr0_c;
                out_llr1 <= llr1_c;
            end
        end
    end

    // R5: a valid input produces a valid output on the next cycle.
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R5: no output strobe without an input strobe.
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R6: outputs keep their values across an idle cycle.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_llr0) && $stable(out_llr1)));
    // R3: the most negative code never leaves the block.
    p_clip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_llr0 != {1'b1, {(LLR_W-1){1'b0}}}) &&
                      (out_llr1 != {1'b1, {(LLR_W-1){1'b0}}}));
    // R4: a zero estimate gives a zero first-bit LLR.
    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_est == '0) |=> out_llr0 == '0);
    // R4: an estimate of +-2.0 gives a zero second-bit LLR.
    p_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (int'(in_est) == TWO_RAW || int'(in_est) == -TWO_RAW))
        |=> out_llr1 == '0);
    // R9: first-bit LLR sign follows the estimate sign.
    p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_llr0[LLR_W-1] == $past(in_est[IN_W-1])));
endmodule

// File: tb/test_pam4_llr_mapper.sv
module test_pam4_llr_mapper;
    localparam int IN_W  = 12;
    localparam int LLR_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0] in_est = '0;
    logic out_valid, out_valid_a;
    logic signed [LLR_W-1:0] out_llr0, out_llr1, out_llr0_a, out_llr1_a;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    pam4_llr_mapper #(.USE_TABLE(1'b1)) i_pam4_llr_mapper (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_est(in_est),
        .out_valid(out_valid), .out_llr0(out_llr0), .out_llr1(out_llr1));

    pam4_llr_mapper #(.USE_TABLE(1'b0)) i_pam4_llr_mapper_arith (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_est(in_est),
        .out_valid(out_valid_a), .out_llr0(out_llr0_a), .out_llr1(out_llr1_a));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Floor division by 16 and saturation (R2), written without shifts.
    function automatic int ref_addr(input int v);
        int q;
        q = (v >= 0) ? v / 16 : -((-v + 15) / 16);
        if (q > 63) q = 63;
        if (q < -64) q = -64;
        return q;
    endfunction

    function automatic int sq(input int a);
        return a * a;
    endfunction

    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int clip63(input int v);
        return (v > 63) ? 63 : ((v < -63) ? -63 : v);
    endfunction

    // R1: min squared distance differences, levels at -48,-16,+16,+48 steps.
    function automatic int ref_llr0(input int q);
        return clip63((mn(sq(q + 48), sq(q + 16)) - mn(sq(q - 16), sq(q - 48))) / 64);
    endfunction

    function automatic int ref_llr1(input int q);
        return clip63((mn(sq(q + 16), sq(q - 16)) - mn(sq(q + 48), sq(q - 48))) / 64);
    endfunction

    task automatic apply(input int v);
        int q;
        @(negedge clk);
        in_valid = 1'b1;
        in_est   = IN_W'(v);
        @(negedge clk);
        q = ref_addr(v);
        check("R5 out_valid", int'(out_valid), 1);
        check("R1 llr0", int'(out_llr0), ref_llr0(q));
        check("R1 llr1", int'(out_llr1), ref_llr1(q));
        check("R8 llr0 variants", int'(out_llr0_a), int'(out_llr0));
        check("R8 llr1 variants", int'(out_llr1_a), int'(out_llr1));
        if (out_llr0 == -7'sd64 || out_llr1 == -7'sd64) check("R3 no -64", 1, 0);
        check("R9 sign", int'(out_llr0[LLR_W-1]), (v < 0) ? 1 : 0);
    endtask

    task automatic idle(input int v, input int h0, input int h1);
        @(negedge clk);
        in_valid = 1'b0;
        in_est   = IN_W'(v);
        @(negedge clk);
        check("R5 idle strobe", int'(out_valid), 0);
        check("R6 hold llr0", int'(out_llr0), h0);
        check("R6 hold llr1", int'(out_llr1), h1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4ns * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 out_valid", int'(out_valid), 0);
        check("R7 llr0", int'(out_llr0), 0);
        check("R7 llr1", int'(out_llr1), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 boundaries and R2/R3 rails
        apply(0);     check("R4 llr0 at 0", int'(out_llr0), 0);
        apply(512);   check("R4 llr1 at +2", int'(out_llr1), 0);
        apply(-512);  check("R4 llr1 at -2", int'(out_llr1), 0);
        apply(2047);  check("R3 top rail llr0", int'(out_llr0), 63);
        apply(-2048); check("R3 bottom rail llr0", int'(out_llr0), -63);
        apply(-1);    check("R2 floor of -1/256", int'(out_llr0), -1);

        // R6: idle cycles with changing estimates
        begin
            int h0, h1;
            h0 = int'(out_llr0);
            h1 = int'(out_llr1);
            idle(1000, h0, h1);
            idle(-1500, h0, h1);
        end

        // Full sweep, every 64th vector followed by an idle cycle (R1, R2, R8)
        for (int v = -2048; v < 2048; v++) begin
            apply(v);
            if ((v & 63) == 0) idle(-v, int'(out_llr0), int'(out_llr1));
        end

        // R7: reset mid-stream clears the outputs
        @(negedge clk);
        in_valid = 1'b1;
        in_est   = 12'sd700;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R7 reset valid", int'(out_valid), 0);
        check("R7 reset llr0", int'(out_llr0), 0);
        in_valid = 1'b0;
        finish_run();
    end
endmodule